// File: doc/BRIEF.md
# Byte-Addressed I2C Target with Self-Clearing Soft Reset

This block is an I2C target that exposes a 256-location byte space behind an auto-incrementing pointer. The low locations are plain read/write registers, one location is a control register whose most significant bit requests a soft reset, and every location above it is general-purpose SRAM. A fast system clock samples SCL and SDA. The block pulls SDA low through an output-enable and never drives SCL.

A write transfer sends the target address, then one pointer byte, then any number of data bytes. A read transfer streams bytes starting at the current pointer. If a data byte lands on the control register with its top bit set, the target resets itself inside that byte's acknowledge slot. The master therefore sees a NACK. The pointer and the low registers return to their power-on values, and the SRAM keeps its contents. The master is expected to close the transfer with a STOP.

Top module: `i2c_softrst_target`

## Requirements
- R1: The target acknowledges the 7-bit address 1101000b (write when bit 0 of the address byte is 0, read when 1). Any other address is NACKed, and the target then ignores the bus until the next START.
- R2: In a write transfer, the first byte after the address loads the pointer. Each following byte is stored at the pointer and acknowledged, and the pointer then increments, wrapping from FFh to 00h.
- R3: A read returns the byte at the pointer, MSB first, and increments the pointer. Reading continues while the master ACKs. After a master NACK the target leaves SDA released until the next START.
- R4: Locations 00h to 12h are full 8-bit read/write registers and hold 00h after reset.
- R5: Location 13h always reads 00h. Writing it with bit 7 clear changes nothing.
- R6: A data byte written to location 13h with bit 7 set is NACKed: SDA is not pulled low during its ninth clock.
- R7: After a soft reset, locations 00h to 12h read 00h and the pointer is 00h.
- R8: Locations 14h to FFh keep their contents across a soft reset.
- R9: After a soft reset, further bytes of the same transfer are NACKed and not stored, up to the next START.
- R10: A repeated START restarts address reception. A STOP ends the transfer and leaves the pointer unchanged.
- R11: The target changes its SDA drive only while SCL is low, and it has no SCL output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line (wired level) |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The assertions assume a well-formed master. SDA changes only while SCL is low, except at START and STOP. SCL phases last several system clocks longer than the synchronizer delay. The master never issues START or STOP while the target is pulling SDA low. The bench master changes SDA a quarter bit-time after each SCL fall and holds each SCL phase for two quarter periods, which keeps it within these limits. Random write and read bursts never put bit 7 into location 13h except in the directed soft-reset case, so the reference model stays exact.

// File: rtl/i2c_srt_pkg.sv
package i2c_srt_pkg;
   localparam int BYTE_W = 8;
   typedef logic [BYTE_W-1:0] byte_t;
   typedef enum logic [3:0] {
      S_IDLE, S_ADDR, S_AACK, S_PTR, S_PACK, S_WDAT, S_DACK, S_TX, S_MACK
   } eng_st_t;
endpackage

// File: rtl/i2c_srt_pins.sv
module i2c_srt_pins #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int TOP = SYNC_STAGES - 1;

   logic [TOP:0] scl_pipe, sda_pipe;
   logic         scl_d, sda_d;

   // bus idles high, so synchronizers reset to 1
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_d    <= 1'b1;
         sda_d    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
         sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
         scl_d    <= scl_pipe[TOP];
         sda_d    <= sda_pipe[TOP];
      end
   end

   assign scl_lvl   = scl_pipe[TOP];
   assign sda_lvl   = sda_pipe[TOP];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_det = scl_lvl & scl_d & sda_d & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_d & ~sda_d & sda_lvl;
endmodule

// File: rtl/i2c_srt_engine.sv
module i2c_srt_engine
   import i2c_srt_pkg::*;
#(
   parameter logic [6:0] TGT_ADDR = 7'h68,
   parameter int         CTRL_REG = 19
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  scl_rise,
   input  logic  scl_fall,
   input  logic  start_det,
   input  logic  stop_det,
   input  logic  sda_lvl,
   input  byte_t ptr,
   input  byte_t rdata,
   output logic  sda_oe,
   output logic  ptr_ld,
   output logic  wr_en,
   output logic  rd_en,
   output byte_t wdata,
   output logic  soft_rst,
   output logic  eng_idle
);
   localparam byte_t CTRL_B = byte_t'(CTRL_REG);
   localparam int    CNT_W  = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

   eng_st_t          st;
   logic [CNT_W-1:0] bitcnt;
   byte_t            rx, tx;
   logic             rw, mack, srq, oe_q;
   logic             fall8, rst_req;

   // strobes are combinational so the store acts on the same edge
   always_comb begin
      fall8   = scl_fall && (bitcnt == FULL);
      rst_req = !srq && fall8 && (st == S_WDAT) && (ptr == CTRL_B) && rx[BYTE_W-1];
      ptr_ld  = !srq && fall8 && (st == S_PTR);
      wr_en   = !srq && fall8 && (st == S_WDAT) && !rst_req;
      rd_en   = !srq && scl_fall &&
                (((st == S_AACK) && rw) || ((st == S_MACK) && mack));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         bitcnt <= '0;
         rx     <= '0;
         tx     <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         oe_q   <= 1'b0;
         srq    <= 1'b0;
      end else begin
         srq <= rst_req;
         if (srq) begin
            st     <= S_IDLE;
            bitcnt <= '0;
            rx     <= '0;
            tx     <= '0;
            rw     <= 1'b0;
            mack   <= 1'b0;
            oe_q   <= 1'b0;
         end else if (start_det) begin
            st     <= S_ADDR;
            bitcnt <= '0;
            oe_q   <= 1'b0;
         end else if (stop_det) begin
            st   <= S_IDLE;
            oe_q <= 1'b0;
         end else begin
            unique case (st)
               S_ADDR, S_PTR, S_WDAT: begin
                  if (scl_rise && (bitcnt != FULL)) begin
                     rx     <= {rx[BYTE_W-2:0], sda_lvl};
                     bitcnt <= bitcnt + 1'b1;
                  end else if (fall8) begin
                     if (st == S_ADDR) begin
                        if (rx[BYTE_W-1:1] == TGT_ADDR) begin
                           oe_q <= 1'b1;
                           rw   <= rx[0];
                           st   <= S_AACK;
                        end else begin
                           st <= S_IDLE;
                        end
                     end else if (st == S_PTR) begin
                        oe_q <= 1'b1;
                        st   <= S_PACK;
                     end else if (rst_req) begin
                        st <= S_IDLE;
                     end else begin
                        oe_q <= 1'b1;
                        st   <= S_DACK;
                     end
                  end
               end
               S_AACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        tx     <= rdata;
                        oe_q   <= ~rdata[BYTE_W-1];
                        bitcnt <= CNT_W'(1);
                        st     <= S_TX;
                     end else begin
                        oe_q <= 1'b0;
                        st   <= S_PTR;
                     end
                  end
               end
               S_PACK, S_DACK: begin
                  if (scl_fall) begin
                     oe_q   <= 1'b0;
                     bitcnt <= '0;
                     st     <= S_WDAT;
                  end
               end
               S_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == FULL) begin
                        oe_q <= 1'b0;
                        st   <= S_MACK;
                     end else begin
                        oe_q   <= ~tx[BYTE_W-2];
                        tx     <= {tx[BYTE_W-2:0], 1'b0};
                        bitcnt <= bitcnt + 1'b1;
                     end
                  end
               end
               S_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     if (mack) begin
                        tx     <= rdata;
                        oe_q   <= ~rdata[BYTE_W-1];
                        bitcnt <= CNT_W'(1);
                        st     <= S_TX;
                     end else begin
                        st <= S_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = oe_q;
   assign wdata    = rx;
   assign soft_rst = srq;
   assign eng_idle = (st == S_IDLE);
endmodule

// File: rtl/i2c_srt_store.sv
module i2c_srt_store
   import i2c_srt_pkg::*;
#(
   parameter int    CTRL_REG = 19,
   parameter int    SRAM_LO  = 20,
   parameter byte_t REG_INIT = 8'h00
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  soft_rst,
   input  logic  ptr_ld,
   input  logic  wr_en,
   input  logic  rd_en,
   input  byte_t wdata,
   output byte_t ptr,
   output byte_t rdata
);
   localparam byte_t SRAM_B = byte_t'(SRAM_LO);
   localparam int    LAST   = (1 << BYTE_W) - 1;

   byte_t reg_rd [CTRL_REG];
   byte_t sram   [SRAM_LO:LAST];

   // pointer: cleared by either reset, loaded, or stepped per data byte
   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst)    ptr <= '0;
      else if (ptr_ld)           ptr <= wdata;
      else if (wr_en || rd_en)   ptr <= ptr + 1'b1;
   end

   // placeholder registers: one flop group per location
   for (genvar i = 0; i < CTRL_REG; i++) begin : g_reg
      byte_t q;
      always_ff @(posedge clk) begin
         if (!rst_n || soft_rst)                  q <= REG_INIT;
         else if (wr_en && (ptr == byte_t'(i)))   q <= wdata;
      end
      assign reg_rd[i] = q;
   end

   // general-purpose storage: no reset of any kind
   always_ff @(posedge clk) begin
      if (wr_en && (ptr >= SRAM_B)) sram[ptr] <= wdata;
   end

   // control location falls through to zero
   always_comb begin
      rdata = '0;
      for (int i = 0; i < CTRL_REG; i++) begin
         if (ptr == byte_t'(i)) rdata = reg_rd[i];
      end
      if (ptr >= SRAM_B) rdata = sram[ptr];
   end
endmodule

// File: rtl/i2c_softrst_target.sv
module i2c_softrst_target #(
   parameter logic [6:0] TGT_ADDR    = 7'h68,
   parameter int         CTRL_REG    = 19,
   parameter int         SRAM_LO     = 20,
   parameter int         SYNC_STAGES = 2,
   parameter logic [7:0] REG_INIT    = 8'h00
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_oe
);
   import i2c_srt_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (SRAM_LO != CTRL_REG + 1) begin : g_bad_map
      $error("SRAM_LO must directly follow CTRL_REG");
   end
   if ((CTRL_REG < 1) || (CTRL_REG > 254)) begin : g_bad_ctrl
      $error("CTRL_REG out of range");
   end

   logic  scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic  ptr_ld, wr_en, rd_en, soft_rst, eng_idle;
   byte_t ptr, rdata, wdata;

   i2c_srt_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   i2c_srt_engine #(.TGT_ADDR(TGT_ADDR), .CTRL_REG(CTRL_REG)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .sda_lvl(sda_lvl),
      .ptr(ptr), .rdata(rdata), .sda_oe(sda_oe), .ptr_ld(ptr_ld),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .soft_rst(soft_rst),
      .eng_idle(eng_idle)
   );

   i2c_srt_store #(.CTRL_REG(CTRL_REG), .SRAM_LO(SRAM_LO), .REG_INIT(REG_INIT)) u_store (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .ptr_ld(ptr_ld),
      .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .ptr(ptr), .rdata(rdata)
   );
endmodule

// File: rtl/i2c_softrst_chk.sv
module i2c_softrst_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sda_oe,
   input logic       scl_lvl,
   input logic       soft_rst,
   input logic       eng_idle,
   input logic       wr_en,
   input logic [7:0] ptr
);
   // SDA drive moves only in the low phase of SCL
   p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);

   // the reset pulse coincides with a released line (the NACK)
   p_nack_swrst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> !sda_oe);

   // the reset request is a single-cycle pulse with no store in flight
   p_swrst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);

   p_no_write_swrst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |-> !wr_en);

   // pointer returns to location zero right after the pulse
   p_ptr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ptr == 8'h00));

   // an idle engine never holds the line
   p_idle_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_idle |-> !sda_oe);
endmodule

bind i2c_softrst_target i2c_softrst_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_lvl(scl_lvl),
   .soft_rst(soft_rst), .eng_idle(eng_idle), .wr_en(wr_en), .ptr(ptr)
);

// File: tb/sim_i2c_softrst_target.sv
module sim_i2c_softrst_target;
   localparam int         CLK_PERIOD = 10;
   localparam int         Q          = 4;
   localparam logic [6:0] DEV        = 7'h68;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_low = 1'b0;
   logic sda_oe, sda;
   assign sda = !(m_low || sda_oe);

   i2c_softrst_target u0 (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .sda_oe(sda_oe));

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0, viol = 0;
   bit done = 1'b0;
   logic [7:0] mdl [256];
   logic [7:0] wbuf [256];
   logic [7:0] mptr;
   logic prev_oe = 1'b0;

   // R11 monitor: drive changes seen while the bench holds SCL high
   always @(negedge clk) begin
      if (rst_n && scl && (sda_oe !== prev_oe)) viol++;
      prev_oe = sda_oe;
   end

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", req, act, exp);
      end
   endtask

   function automatic void mwrite(input logic [7:0] a, input logic [7:0] d);
      if (a != 8'h13) mdl[a] = d;
   endfunction

   task automatic wq; repeat (Q) @(negedge clk); endtask

   task automatic send_bit(input logic b);
      m_low = !b; wq; scl = 1'b1; wq; wq; scl = 1'b0; wq;
   endtask

   task automatic get_bit(output logic b);
      m_low = 1'b0; wq; scl = 1'b1; wq; b = sda; wq; scl = 1'b0; wq;
   endtask

   task automatic i2c_start;
      m_low = 1'b0; wq; scl = 1'b1; wq; m_low = 1'b1; wq; scl = 1'b0; wq;
   endtask

   task automatic i2c_stop;
      m_low = 1'b1; wq; scl = 1'b1; wq; m_low = 1'b0; wq;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic x;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      get_bit(x);
      ack = !x;
   endtask

   task automatic recv_byte(output logic [7:0] d, input logic mack);
      logic x;
      for (int i = 7; i >= 0; i--) begin get_bit(x); d[i] = x; end
      send_bit(!mack);
   endtask

   task automatic wr_burst(input logic [7:0] p, input int n);
      logic ack;
      i2c_start;
      send_byte({DEV, 1'b0}, ack); chk("R1 address ack (write)", 8'(ack), 8'h01);
      send_byte(p, ack);           chk("R2 pointer byte ack", 8'(ack), 8'h01);
      mptr = p;
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], ack); chk("R2 data byte ack", 8'(ack), 8'h01);
         mwrite(mptr, wbuf[i]);
         mptr++;
      end
      i2c_stop;
   endtask

   task automatic rd_stream(input int n, input string req);
      logic [7:0] d;
      for (int i = 0; i < n; i++) begin
         recv_byte(d, i != n - 1);
         chk(req, d, mdl[mptr]);
         mptr++;
      end
      i2c_stop;
   endtask

   task automatic rd_burst(input logic [7:0] p, input int n, input string req);
      logic ack;
      i2c_start;
      send_byte({DEV, 1'b0}, ack);
      send_byte(p, ack);
      i2c_start;                      // R10 repeated START
      send_byte({DEV, 1'b1}, ack); chk("R10 read address after repeated START", 8'(ack), 8'h01);
      mptr = p;
      rd_stream(n, req);
   endtask

   task automatic rd_cur(input int n, input string req);
      logic ack;
      i2c_start;
      send_byte({DEV, 1'b1}, ack); chk("R1 address ack (read)", 8'(ack), 8'h01);
      rd_stream(n, req);
   endtask

   task automatic summary;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary;
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] d;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) mdl[i] = (i <= 8'h13) ? 8'h00 : 8'hxx;
      mptr = 8'h00;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      wq;
      chk("R4 reset: SDA released", 8'(sda_oe), 8'h00);
      rd_burst(8'h00, 20, "R4 reset value of low registers");

      // fill whole space; 256 bytes wrap the pointer back to 00h
      for (int i = 0; i < 256; i++)
         wbuf[i] = 8'((i * 37 + 11) & ((i == 8'h13) ? 8'h7F : 8'hFF));
      wr_burst(8'h00, 256);
      rd_cur(4, "R2 pointer wrapped to 00h after 256 bytes");

      // random bursts with read-back
      for (int t = 0; t < 16; t++) begin
         logic [7:0] p;
         int n;
         p = 8'($urandom_range(0, 255));
         n = $urandom_range(1, 6);
         for (int i = 0; i < n; i++) begin
            wbuf[i] = 8'($urandom_range(0, 255));
            if (8'(p + 8'(i)) == 8'h13) wbuf[i] &= 8'h7F;
         end
         wr_burst(p, n);
         rd_burst(p, n, "R2 R3 random burst read-back");
      end

      // directed wrap across FFh
      wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
      wr_burst(8'hFE, 3);
      rd_burst(8'hFE, 3, "R2 write and read across FFh to 00h");

      // control register ignores low bits
      wbuf[0] = 8'h7F;
      wr_burst(8'h13, 1);
      rd_burst(8'h12, 2, "R5 location 13h reads zero");

      // STOP keeps pointer
      i2c_start;
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h30, ack);
      i2c_stop;
      mptr = 8'h30;
      rd_cur(1, "R10 pointer kept across STOP");

      // foreign address
      i2c_start;
      send_byte(8'hA0, ack); chk("R1 foreign address NACK", 8'(ack), 8'h00);
      send_byte(8'h45, ack); chk("R1 ignored until START", 8'(ack), 8'h00);
      i2c_stop;
      rd_cur(1, "R1 pointer untouched by foreign transfer");

      // master NACK stops the stream
      i2c_start;
      send_byte({DEV, 1'b1}, ack);
      recv_byte(d, 1'b0);
      chk("R3 byte before master NACK", d, mdl[mptr]);
      mptr++;
      recv_byte(d, 1'b0);
      chk("R3 no drive after master NACK", d, 8'hFF);
      i2c_stop;

      // soft reset mid-transfer
      i2c_start;
      send_byte({DEV, 1'b0}, ack);
      send_byte(8'h10, ack);
      send_byte(8'h11, ack); chk("R2 data ack before soft reset", 8'(ack), 8'h01);
      send_byte(8'h22, ack);
      send_byte(8'h33, ack);
      send_byte(8'h80, ack); chk("R6 reset byte NACKed", 8'(ack), 8'h00);
      send_byte(8'h55, ack); chk("R9 byte after soft reset NACKed", 8'(ack), 8'h00);
      i2c_stop;
      for (int i = 0; i < 8'h13; i++) mdl[i] = 8'h00;
      mptr = 8'h00;
      chk("R6 SDA released after soft reset", 8'(sda_oe), 8'h00);
      rd_cur(1, "R7 R9 pointer 00h and register 00h clear");
      rd_burst(8'h0E, 5, "R7 low registers cleared");
      rd_burst(8'h13, 8, "R8 SRAM kept across soft reset");
      rd_burst(8'hF8, 8, "R8 top SRAM kept across soft reset");

      chk("R11 SDA drive change while SCL high", 8'(viol), 8'h00);

      done = 1'b1;
      summary;
      $finish;
   end
endmodule